// File: doc/BRIEF.md
# Frame Buffer Fetch Address Engine

This engine issues the memory read requests that feed a display controller's pixel path. Each request carries a byte address and a length in 32-bit words. It steps through a programmed address window, from a base address up to an inclusive ceiling, in bursts of a configured size. At the end of a window it either starts the next frame or stops. The memory behind the requests, the pixel FIFO and the raster timing all sit outside the block.

Three kinds of fetch are supported. A colour table can be fetched once on its own. A colour table can be fetched once and followed by continuous pixel frames. Pixel frames can be fetched with no colour table. Pixel frames either repeat from a single buffer or alternate between two buffers. Each buffer has its own end-of-frame pulse, and a separate pulse marks the end of the colour table fetch.

Windows must be word aligned, with the ceiling equal to the base plus four times the word count, minus one. Each window is taken from the configuration inputs at the moment the window starts.

Top module: `fbdma_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_valid`, `eof0`, `eof1` and `pal_done` are low.
- R2: `cfg_burst` selects the burst length: code 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8 and 4 gives 16. Codes 5, 6 and 7 are invalid and raise no request while the window that latched them is active.
- R3: A request holds `rd_addr` and `rd_len` steady until `rd_ready` accepts it. Each accepted burst moves the address on by four bytes per word.
- R4: The ceiling is inclusive. No burst reads past the ceiling, and the last burst of a window is cut to the (ceiling − address + 1)/4 words that remain.
- R5: With `cfg_load_mode` = 2 (pixels only) and `cfg_dual` = 0, frames come from base0..ceil0 only. The engine restarts at base0 after each frame and pulses `eof0` at the end of each one.
- R6: With `cfg_dual` = 1, pixel frames alternate between buffer 0 (base0..ceil0) and buffer 1 (base1..ceil1). Finishing buffer 0 pulses `eof0` and finishing buffer 1 pulses `eof1`.
- R7: With `cfg_load_mode` = 1 (colour table only), base0..ceil0 is fetched once and `pal_done` pulses. No further request is made until `enable` has been low.
- R8: With `cfg_load_mode` = 0, a colour table of 32 bytes (`cfg_pal_wide` = 0) or 512 bytes (`cfg_pal_wide` = 1) is fetched from base0 first and `pal_done` pulses. Pixel frames from buffer 0 follow.
- R9: `cfg_load_mode` = 3 is reserved and raises no request.
- R10: Base, ceiling, burst code and dual selection are sampled when a window starts. A change made in the middle of a frame takes effect at the next frame.
- R11: When `enable` is low, `rd_valid` drops in the same cycle and the engine returns to idle. When `enable` is raised again, the fetch restarts from the beginning of the sequence.
- R12: Each event pulse lasts one cycle and appears in the cycle after the clock edge that accepted the last burst of its window. At most one event is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the fetch sequence |
| cfg_dual | input | 1 | Alternate between two pixel buffers |
| cfg_burst | input | 3 | Burst length code |
| cfg_load_mode | input | 2 | 0 table then pixels, 1 table only, 2 pixels only, 3 reserved |
| cfg_pal_wide | input | 1 | Table length: 512 bytes when set, 32 bytes when clear |
| cfg_base0 | input | ADDR_W | Buffer 0 first byte address |
| cfg_ceil0 | input | ADDR_W | Buffer 0 last byte address |
| cfg_base1 | input | ADDR_W | Buffer 1 first byte address |
| cfg_ceil1 | input | ADDR_W | Buffer 1 last byte address |
| rd_valid | output | 1 | Read request present |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Byte address of the burst |
| rd_len | output | 5 | Burst length in words |
| eof0 | output | 1 | Buffer 0 frame finished |
| eof1 | output | 1 | Buffer 1 frame finished |
| pal_done | output | 1 | Colour table fetch finished |

## Verification
The first request of a window appears one clock after the engine sees `enable` in idle, or one clock after the previous window's last burst is accepted. An address advance becomes visible on the clock after the acceptance. An event pulse appears in the cycle after the accepting edge. Dropping `enable` removes the request in the same cycle. The reference model advances its state on each rising edge from the inputs the bench set just after the previous edge. Outputs are compared at the falling edge, so every result is read exactly in the cycle it is due. The targeted checks wait the same number of edges before they sample.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

  localparam int LEN_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PAL  = 2'd1,
    PH_DATA = 2'd2,
    PH_HALT = 2'd3
  } fbdma_phase_e;

  localparam logic [1:0] LM_BOTH = 2'd0;
  localparam logic [1:0] LM_PAL  = 2'd1;
  localparam logic [1:0] LM_DATA = 2'd2;
  localparam logic [1:0] LM_NONE = 2'd3;

  // burst code to word count, zero for reserved codes
  function automatic logic [LEN_W-1:0] burst_words(input logic [2:0] code);
    logic [LEN_W-1:0] w;
    case (code)
      3'd0:    w = 5'd1;
      3'd1:    w = 5'd2;
      3'd2:    w = 5'd4;
      3'd3:    w = 5'd8;
      3'd4:    w = 5'd16;
      default: w = 5'd0;
    endcase
    return w;
  endfunction

  function automatic logic burst_code_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

endpackage

// File: rtl/fbdma_burst_calc.sv
module fbdma_burst_calc
  import fbdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] lim_addr,
  output logic [LEN_W-1:0]  len,
  output logic              last,
  output logic              code_ok,
  output logic [ADDR_W-1:0] step
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] rem_words;
  logic [ADDR_W-1:0] bw_ext;
  logic [LEN_W-1:0]  bw;

  assign bw        = burst_words(code);
  assign bw_ext    = ADDR_W'(bw);
  assign rem_words = (lim_addr - cur_addr + ONE) >> 2;
  assign code_ok   = burst_code_ok(code);

  always_comb begin
    if (rem_words < bw_ext) begin
      len  = rem_words[LEN_W-1:0];
      last = 1'b1;
    end else begin
      len  = bw;
      last = (rem_words == bw_ext);
    end
  end

  assign step = ADDR_W'(len) << 2;

endmodule

// File: rtl/fbdma_seg_sel.sv
module fbdma_seg_sel
  import fbdma_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int PAL_SMALL_BYTES = 32,
  parameter int PAL_LARGE_BYTES = 512
) (
  input  logic              sel_pal,
  input  logic              sel_buf,
  input  logic [1:0]        lmode,
  input  logic              pal_wide,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] ceil0,
  input  logic [ADDR_W-1:0] base1,
  input  logic [ADDR_W-1:0] ceil1,
  output logic [ADDR_W-1:0] seg_start,
  output logic [ADDR_W-1:0] seg_end
);

  localparam logic [ADDR_W-1:0] PAL_S_SPAN = ADDR_W'(PAL_SMALL_BYTES - 1);
  localparam logic [ADDR_W-1:0] PAL_L_SPAN = ADDR_W'(PAL_LARGE_BYTES - 1);

  always_comb begin
    if (sel_pal) begin
      seg_start = base0;
      if (lmode == LM_PAL) seg_end = ceil0;
      else                 seg_end = base0 + (pal_wide ? PAL_L_SPAN : PAL_S_SPAN);
    end else begin
      seg_start = sel_buf ? base1 : base0;
      seg_end   = sel_buf ? ceil1 : ceil0;
    end
  end

endmodule

// File: rtl/fbdma_event_gen.sv
module fbdma_event_gen #(
  parameter int N_EVT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] fire,
  output logic [N_EVT-1:0] pulse
);

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= fire[i];
    end
  end

endmodule

// File: rtl/fbdma_engine.sv
module fbdma_engine
  import fbdma_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int PAL_SMALL_BYTES = 32,
  parameter int PAL_LARGE_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_dual,
  input  logic [2:0]        cfg_burst,
  input  logic [1:0]        cfg_load_mode,
  input  logic              cfg_pal_wide,
  input  logic [ADDR_W-1:0] cfg_base0,
  input  logic [ADDR_W-1:0] cfg_ceil0,
  input  logic [ADDR_W-1:0] cfg_base1,
  input  logic [ADDR_W-1:0] cfg_ceil1,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic              eof0,
  output logic              eof1,
  output logic              pal_done
);

  localparam int N_EVT = 3;

  fbdma_phase_e      phase_q;
  logic [1:0]        mode_q;
  logic [2:0]        code_q;
  logic              buf_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] lim_q;

  // named internal events
  logic              in_fetch;
  logic              accept;
  logic              seg_done;
  logic              load;
  logic              sel_pal;
  logic              sel_buf;
  logic              go_halt;
  logic [N_EVT-1:0]  fire;
  logic [N_EVT-1:0]  pulse;

  logic [LEN_W-1:0]  len_w;
  logic              last_w;
  logic              code_ok_w;
  logic [ADDR_W-1:0] step_w;
  logic [ADDR_W-1:0] seg_start_w;
  logic [ADDR_W-1:0] seg_end_w;

  fbdma_burst_calc #(.ADDR_W(ADDR_W)) u_burst (
    .code     (code_q),
    .cur_addr (cur_q),
    .lim_addr (lim_q),
    .len      (len_w),
    .last     (last_w),
    .code_ok  (code_ok_w),
    .step     (step_w)
  );

  fbdma_seg_sel #(
    .ADDR_W          (ADDR_W),
    .PAL_SMALL_BYTES (PAL_SMALL_BYTES),
    .PAL_LARGE_BYTES (PAL_LARGE_BYTES)
  ) u_seg (
    .sel_pal   (sel_pal),
    .sel_buf   (sel_buf),
    .lmode     (cfg_load_mode),
    .pal_wide  (cfg_pal_wide),
    .base0     (cfg_base0),
    .ceil0     (cfg_ceil0),
    .base1     (cfg_base1),
    .ceil1     (cfg_ceil1),
    .seg_start (seg_start_w),
    .seg_end   (seg_end_w)
  );

  assign in_fetch = (phase_q == PH_PAL) || (phase_q == PH_DATA);
  assign rd_valid = enable && in_fetch && code_ok_w;
  assign rd_addr  = cur_q;
  assign rd_len   = len_w;
  assign accept   = rd_valid && rd_ready;
  assign seg_done = accept && last_w;

  // next window selection
  always_comb begin
    load    = 1'b0;
    sel_pal = 1'b0;
    sel_buf = 1'b0;
    go_halt = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (cfg_load_mode != LM_NONE) begin
          load    = 1'b1;
          sel_pal = (cfg_load_mode != LM_DATA);
        end
      end
      PH_PAL: begin
        if (seg_done) begin
          if (mode_q == LM_PAL) go_halt = 1'b1;
          else                  load    = 1'b1;
        end
      end
      PH_DATA: begin
        if (seg_done) begin
          load    = 1'b1;
          sel_buf = cfg_dual && !buf_q;
        end
      end
      default: ;
    endcase
  end

  assign fire[0] = seg_done && (phase_q == PH_DATA) && !buf_q;
  assign fire[1] = seg_done && (phase_q == PH_DATA) &&  buf_q;
  assign fire[2] = seg_done && (phase_q == PH_PAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= LM_NONE;
      code_q  <= 3'd0;
      buf_q   <= 1'b0;
      cur_q   <= '0;
      lim_q   <= '0;
    end else if (!enable) begin
      phase_q <= PH_IDLE;
    end else if (load) begin
      cur_q   <= seg_start_w;
      lim_q   <= seg_end_w;
      code_q  <= cfg_burst;
      buf_q   <= sel_buf;
      phase_q <= sel_pal ? PH_PAL : PH_DATA;
      if (phase_q == PH_IDLE) mode_q <= cfg_load_mode;
    end else if (go_halt) begin
      phase_q <= PH_HALT;
    end else if (accept) begin
      cur_q   <= cur_q + step_w;
    end
  end

  fbdma_event_gen #(.N_EVT(N_EVT)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .pulse (pulse)
  );

  assign eof0     = pulse[0];
  assign eof1     = pulse[1];
  assign pal_done = pulse[2];

endmodule

// File: rtl/fbdma_chk.sv
module fbdma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [4:0]        rd_len,
  input logic              eof0,
  input logic              eof1,
  input logic              pal_done,
  input logic [ADDR_W-1:0] seg_lim
);

  logic [ADDR_W:0] last_byte;
  assign last_byte = ({1'b0, rd_addr} + ((ADDR_W+1)'(rd_len) << 2)) - (ADDR_W+1)'(1);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (!enable || (rd_valid && $stable(rd_addr) && $stable(rd_len))));

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_len != 5'd0 && rd_len <= 5'd16));

  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (last_byte <= {1'b0, seg_lim}));

  p_evt_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eof0, eof1, pal_done}));

  p_evt_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eof0 || eof1 || pal_done) |-> $past(rd_valid && rd_ready));

  p_pal_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pal_done |=> !pal_done);

endmodule

bind fbdma_engine fbdma_chk #(.ADDR_W(ADDR_W)) u_fbdma_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_addr  (rd_addr),
  .rd_len   (rd_len),
  .eof0     (eof0),
  .eof1     (eof1),
  .pal_done (pal_done),
  .seg_lim  (lim_q)
);

// File: tb/tb_fbdma_engine.sv
module tb_fbdma_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_dual = 1'b0;
  logic [2:0]  cfg_burst = 3'd0;
  logic [1:0]  cfg_load_mode = 2'd2;
  logic        cfg_pal_wide = 1'b0;
  logic [31:0] cfg_base0 = 32'h0, cfg_ceil0 = 32'h3;
  logic [31:0] cfg_base1 = 32'h0, cfg_ceil1 = 32'h3;
  logic        rd_ready = 1'b1;
  logic        rd_valid;
  logic [31:0] rd_addr;
  logic [4:0]  rd_len;
  logic        eof0, eof1, pal_done;

  fbdma_engine dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_dual(cfg_dual),
    .cfg_burst(cfg_burst), .cfg_load_mode(cfg_load_mode), .cfg_pal_wide(cfg_pal_wide),
    .cfg_base0(cfg_base0), .cfg_ceil0(cfg_ceil0), .cfg_base1(cfg_base1), .cfg_ceil1(cfg_ceil1),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len),
    .eof0(eof0), .eof1(eof1), .pal_done(pal_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  int          m_ph = 0;     // 0 idle, 1 table, 2 pixels, 3 stopped
  logic [31:0] m_addr = 0, m_lim = 0;
  logic [2:0]  m_code = 0;
  logic [1:0]  m_mode = 0;
  logic        m_buf = 0;
  logic        m_e0 = 0, m_e1 = 0, m_ep = 0;
  string       cur_req = "R1";

  function automatic int words_of(input logic [2:0] c);
    return (c <= 3'd4) ? (1 << c) : 0;
  endfunction

  function automatic int model_len();
    logic [31:0] left;
    int bw;
    left = (m_lim - m_addr + 32'd1) >> 2;
    bw = words_of(m_code);
    return (left < 32'(bw)) ? int'(left) : bw;
  endfunction

  always @(posedge clk) begin
    m_e0 = 0; m_e1 = 0; m_ep = 0;
    if (!rst_n || !enable) m_ph = 0;
    else if (m_ph == 0) begin
      if (cfg_load_mode != 2'd3) begin
        m_mode = cfg_load_mode; m_code = cfg_burst; m_addr = cfg_base0; m_buf = 0;
        if (cfg_load_mode == 2'd2) begin m_ph = 2; m_lim = cfg_ceil0; end
        else begin
          m_ph = 1;
          m_lim = (cfg_load_mode == 2'd1) ? cfg_ceil0 : cfg_base0 + (cfg_pal_wide ? 32'd511 : 32'd31);
        end
      end
    end else if ((m_ph == 1 || m_ph == 2) && m_code <= 3'd4 && rd_ready) begin
      int n;
      n = model_len();
      if (m_addr + 32'(n * 4) - 32'd1 == m_lim) begin
        if (m_ph == 1) begin
          m_ep = 1;
          if (m_mode == 2'd1) m_ph = 3;
          else begin m_ph = 2; m_buf = 0; m_addr = cfg_base0; m_lim = cfg_ceil0; m_code = cfg_burst; end
        end else begin
          if (m_buf) m_e1 = 1; else m_e0 = 1;
          m_buf = cfg_dual ? !m_buf : 1'b0;
          m_addr = m_buf ? cfg_base1 : cfg_base0;
          m_lim  = m_buf ? cfg_ceil1 : cfg_ceil0;
          m_code = cfg_burst;
        end
      end else m_addr = m_addr + 32'(n * 4);
    end
  end

  // ---------------- comparison and counters ----------------
  int mc_checks = 0, mc_fails = 0;
  int n_eof0 = 0, n_eof1 = 0, n_pal = 0, n_valid = 0;

  always @(negedge clk) begin
    logic        ev;
    logic [40:0] act, exp;
    ev = enable && (m_ph == 1 || m_ph == 2) && m_code <= 3'd4;
    act = {rd_valid, eof0, eof1, pal_done, ev ? rd_len : 5'd0, ev ? rd_addr : 32'd0};
    exp = {ev, m_e0, m_e1, m_ep, ev ? 5'(model_len()) : 5'd0, ev ? m_addr : 32'd0};
    mc_checks++;
    if (act !== exp) begin
      mc_fails++;
      $display("FAIL %s cycle compare at %0t: actual %h expected %h", cur_req, $time, act, exp);
    end
    n_eof0 += int'(eof0); n_eof1 += int'(eof1); n_pal += int'(pal_done); n_valid += int'(rd_valid);
  end

  // ---------------- targeted checks ----------------
  int ex_checks = 0, ex_fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    ex_checks++;
    if (!ok) begin
      ex_fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic stop_engine();
    enable = 1'b0; rd_ready = 1'b1;
    tick(2);
  endtask

  task automatic start_and_look();
    enable = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int s0, s1, sp, sv;
    logic [31:0] held;

    // R1 reset
    cur_req = "R1";
    tick(2);
    @(negedge clk);
    chk(!rd_valid && !eof0 && !eof1 && !pal_done, "R1", {rd_valid, eof0, eof1, pal_done}, 0);
    tick(1); rst_n = 1'b1;
    tick(1);
    @(negedge clk);
    chk(!rd_valid && !eof0 && !eof1 && !pal_done, "R1", {rd_valid, eof0, eof1, pal_done}, 0);

    // R5 single buffer pixels, 10 words in bursts of 4
    cur_req = "R5";
    tick(1);
    cfg_load_mode = 2'd2; cfg_dual = 0; cfg_burst = 3'd2;
    cfg_base0 = 32'h1000; cfg_ceil0 = 32'h1027;
    start_and_look();
    chk(rd_valid && rd_addr == 32'h1000 && rd_len == 5'd4, "R5", {rd_addr, rd_len}, {32'h1000, 5'd4});
    s0 = n_eof0; s1 = n_eof1;
    tick(30);
    chk(n_eof0 - s0 >= 9, "R5", n_eof0 - s0, 9);
    chk(n_eof1 == s1, "R5", n_eof1 - s1, 0);
    stop_engine();

    // R4 clipped final burst
    cur_req = "R4";
    cfg_burst = 3'd4; cfg_base0 = 32'h2000; cfg_ceil0 = 32'h2013;
    start_and_look();
    chk(rd_valid && rd_len == 5'd5, "R4", rd_len, 5);
    stop_engine();
    cfg_burst = 3'd2; cfg_ceil0 = 32'h2017;
    start_and_look();
    chk(rd_len == 5'd4, "R4", rd_len, 4);
    @(negedge clk);
    chk(rd_valid && rd_addr == 32'h2010 && rd_len == 5'd2, "R4", {rd_addr, rd_len}, {32'h2010, 5'd2});
    tick(10);
    stop_engine();

    // R3 stall holds request, then irregular acceptance
    cur_req = "R3";
    cfg_burst = 3'd1; cfg_base0 = 32'h5000; cfg_ceil0 = 32'h503F;
    enable = 1'b1; tick(3);
    rd_ready = 1'b0; tick(1);
    @(negedge clk); held = rd_addr;
    tick(2);
    @(negedge clk);
    chk(rd_valid && rd_addr == held && rd_len == 5'd2, "R3", rd_addr, held);
    for (int i = 0; i < 40; i++) begin
      tick(1);
      rd_ready = (i % 3) != 0;
    end
    stop_engine();

    // R6 dual buffers
    cur_req = "R6";
    cfg_dual = 1; cfg_burst = 3'd1;
    cfg_base0 = 32'h1000; cfg_ceil0 = 32'h100F; cfg_base1 = 32'h8000; cfg_ceil1 = 32'h8017;
    s0 = n_eof0; s1 = n_eof1;
    enable = 1'b1; tick(50);
    chk(n_eof0 - s0 >= 8, "R6", n_eof0 - s0, 8);
    chk(n_eof1 - s1 >= 8, "R6", n_eof1 - s1, 8);
    chk((n_eof0 - s0) - (n_eof1 - s1) <= 1 && (n_eof1 - s1) <= (n_eof0 - s0), "R6",
        (n_eof0 - s0) - (n_eof1 - s1), 0);
    stop_engine();

    // R10 mid-frame register change
    cur_req = "R10";
    cfg_dual = 0; cfg_burst = 3'd0; cfg_base0 = 32'h1000; cfg_ceil0 = 32'h103F;
    enable = 1'b1; tick(4);
    cfg_base0 = 32'h3000; cfg_ceil0 = 32'h300F; cfg_burst = 3'd2;
    @(negedge clk);
    chk(rd_addr[15:12] == 4'h1 && rd_len == 5'd1, "R10", rd_addr, 32'h1000);
    tick(20);
    @(negedge clk);
    chk(rd_addr[15:12] == 4'h3 && rd_len == 5'd4, "R10", rd_addr, 32'h3000);
    stop_engine();

    // R7 table only
    cur_req = "R7";
    cfg_load_mode = 2'd1; cfg_burst = 3'd3; cfg_base0 = 32'h200; cfg_ceil0 = 32'h21F;
    sp = n_pal; s0 = n_eof0;
    start_and_look();
    chk(rd_valid && rd_addr == 32'h200 && rd_len == 5'd8, "R7", {rd_addr, rd_len}, {32'h200, 5'd8});
    tick(20);
    @(negedge clk);
    chk(n_pal - sp == 1, "R7", n_pal - sp, 1);
    chk(!rd_valid && n_eof0 == s0, "R7", rd_valid, 0);
    stop_engine();

    // R8 table then pixels, small and large table
    cur_req = "R8";
    cfg_load_mode = 2'd0; cfg_pal_wide = 0; cfg_burst = 3'd2;
    cfg_base0 = 32'h4000; cfg_ceil0 = 32'h40FF;
    sp = n_pal; s0 = n_eof0;
    enable = 1'b1; tick(3);
    @(negedge clk);
    chk(rd_valid && rd_addr == 32'h4000, "R8", rd_addr, 32'h4000);
    tick(100);
    chk(n_pal - sp == 1, "R8", n_pal - sp, 1);
    chk(n_eof0 - s0 >= 1, "R8", n_eof0 - s0, 1);
    stop_engine();
    cfg_pal_wide = 1; cfg_burst = 3'd4; cfg_ceil0 = 32'h4FFF;
    sp = n_pal;
    enable = 1'b1; tick(8);
    chk(n_pal == sp, "R8", n_pal - sp, 0);
    tick(3);
    chk(n_pal - sp == 1, "R8", n_pal - sp, 1);
    stop_engine();

    // R9 reserved mode
    cur_req = "R9";
    cfg_load_mode = 2'd3;
    sv = n_valid;
    enable = 1'b1; tick(10);
    chk(n_valid == sv, "R9", n_valid - sv, 0);
    stop_engine();

    // R2 burst code decoding
    cur_req = "R2";
    cfg_load_mode = 2'd2; cfg_pal_wide = 0; cfg_burst = 3'd5;
    cfg_base0 = 32'h6000; cfg_ceil0 = 32'h60FF;
    sv = n_valid;
    enable = 1'b1; tick(10);
    chk(n_valid == sv, "R2", n_valid - sv, 0);
    stop_engine();
    cfg_burst = 3'd0;
    start_and_look();
    chk(rd_valid && rd_len == 5'd1, "R2", rd_len, 1);
    @(negedge clk);
    chk(rd_addr == 32'h6004, "R2", rd_addr, 32'h6004);
    stop_engine();
    cfg_burst = 3'd3;
    start_and_look();
    chk(rd_valid && rd_len == 5'd8, "R2", rd_len, 8);
    stop_engine();

    // R11 enable drop and restart
    cur_req = "R11";
    cfg_burst = 3'd0; cfg_base0 = 32'h7000; cfg_ceil0 = 32'h703F;
    enable = 1'b1; tick(5);
    enable = 1'b0; #1;
    chk(!rd_valid, "R11", rd_valid, 0);
    tick(1); enable = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(rd_valid && rd_addr == 32'h7000, "R11", rd_addr, 32'h7000);

    // R12 event timing is compared every cycle; run pixels with a stalling consumer
    cur_req = "R12";
    stop_engine();
    cfg_burst = 3'd1; cfg_ceil0 = 32'h700F;
    s0 = n_eof0;
    enable = 1'b1;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      rd_ready = (i % 2) == 0;
    end
    chk(n_eof0 - s0 >= 3, "R12", n_eof0 - s0, 3);
    stop_engine();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", mc_checks + ex_checks, mc_fails + ex_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      $display("FAIL %s watchdog expired at %0t", cur_req, $time);
      $display("== %0d vectors applied, %0d miscompares ==", mc_checks + ex_checks + 1, mc_fails + ex_fails + 1);
      $finish;
    end
  end

endmodule